// File: doc/BRIEF.md
# HDLC Receive Controller With Status

This block takes a bit-serial HDLC line, one bit per cycle in which the bit-enable is high. It searches for flags, removes the zeros the transmitter inserted after runs of five ones, assembles bytes least-significant bit first and checks each frame against its 16-bit frame check sequence. Payload bytes go into a 64-byte receive buffer, and the host drains that buffer through a simple read port.

Three sticky status bits tell the host what happened: a packet began, a packet ended, or the buffer is more than half full. All four ways a packet can finish raise the same end bit. These are a good frame, a checksum failure, a buffer overrun and a received abort. A two-bit result code says which one it was. Bytes of a frame become readable only when that frame ends. Frames that are too short or that stop off a byte boundary are taken back out of the buffer without any event.

Top module: `hdlc_rx_status`

## Requirements
- R1: The start status bit is set when the first complete byte after a flag (01111110) is assembled. Flags with no byte between them do not set it.
- R2: A frame closed by a flag that holds at least 4 bytes, ends on a byte boundary and leaves a CRC-16-CCITT residue of F0B8h (reflected, all-ones preset, data LSB first) sets the end status bit with result code 0. Its payload reads out in arrival order, and the two check bytes are not readable.
- R3: A frame that meets R2 except for the residue sets the end status bit with result code 1. Its payload, without the last two bytes, stays readable.
- R4: When a byte completes while the buffer holds 64 bytes, the end status bit is set with result code 2. The bytes already stored stay readable, and all further bits are discarded until the next flag.
- R5: Seven consecutive ones inside a frame with at least one byte received set the end status bit with result code 3. The bytes already received stay readable.
- R6: A 0 that follows five consecutive ones is removed from the data. The serial input is ignored in cycles where the bit-enable is low.
- R7: A frame with fewer than 4 bytes between flags raises no end event, and none of its bytes become readable.
- R8: A frame whose closing flag does not fall on a byte boundary raises no end event, and none of its bytes become readable. The next frame reads out correctly.
- R9: The half-full status bit is set in every cycle in which the buffer holds more than 32 bytes. This includes bytes that are not yet readable.
- R10: The status bits stay set until a status-read pulse clears them. A condition that still holds sets its bit again.
- R11: After reset, all status bits and the result code are 0 and no data is readable.
- R12: The read data shows the oldest readable byte whenever the valid output is high. A read pulse advances to the next byte. Reads while nothing is readable have no effect. Bytes of an unfinished frame are not readable.
- R13: Idle ones and repeated flags between frames raise no status event. A single flag can close one frame and open the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Bit-enable for the serial input |
| rx_bit | input | 1 | Serial HDLC data |
| rd_en | input | 1 | Pops one readable byte |
| rd_data | output | 8 | Oldest readable byte |
| rd_valid | output | 1 | At least one byte readable |
| status_rd | input | 1 | Status read pulse; clears the sticky bits |
| stat_start | output | 1 | Sticky packet-start status |
| stat_end | output | 1 | Sticky packet-end status |
| stat_half | output | 1 | Sticky buffer half-full status |
| end_code | output | 2 | Result of the last ended packet: 0 good, 1 CRC, 2 overrun, 3 abort |

## Verification
The assertions assume that the host pulses the read input only for single cycles and that the serial line carries legal stuffed HDLC. Under that assumption the payload can never imitate a flag. They also assume that the buffer occupancy is driven only by the bit processor and the host reads. The bench keeps within these assumptions by generating every frame with a bit-exact stuffer that tracks runs of ones across bytes. It builds every abort and misalignment from raw bit patterns whose runs of ones it controls. Between enabled bits it inserts idle cycles that carry the inverted bit.

// File: rtl/hdlc_rx_pkg.sv
// Shared types and constants for the HDLC receive controller.
// Assumes CRC-16-CCITT in reflected form, with data entering LSB first.
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        RES_GOOD    = 2'd0,
        RES_CRC     = 2'd1,
        RES_OVERRUN = 2'd2,
        RES_ABORT   = 2'd3
    } rx_result_e;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;

    // Advance the reflected CRC over one byte, LSB first.
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ d[k]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
// Bit processor: finds flags and aborts, removes stuffed zeros, assembles
// bytes, runs the CRC and judges each frame as it closes.
// Assumes bit_in is valid only when bit_en is high. Outputs are decoded
// combinationally from the current bit and the registered state.
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
#(
    parameter int MIN_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       fifo_full,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       ev_start,
    output logic       ev_end,
    output rx_result_e end_result,
    output logic       trim_fcs,
    output logic       drop_frame
);
    localparam int NBW = $clog2(MIN_BYTES + 1);
    localparam logic [NBW-1:0] NB_SAT = NBW'(MIN_BYTES);

    logic [2:0]     ones_q, ones_d;
    logic           in_frame_q, in_frame_d;
    logic [7:0]     sh_q, sh_d;
    logic [2:0]     bitcnt_q, bitcnt_d;
    logic [NBW-1:0] nbytes_q, nbytes_d;
    logic [15:0]    crc_q, crc_d;
    logic [7:0]     byte_next;

    // Next-state and event decode for one incoming line bit.
    always_comb begin
        ones_d     = ones_q;
        in_frame_d = in_frame_q;
        sh_d       = sh_q;
        bitcnt_d   = bitcnt_q;
        nbytes_d   = nbytes_q;
        crc_d      = crc_q;
        wr_en      = 1'b0;
        ev_start   = 1'b0;
        ev_end     = 1'b0;
        end_result = RES_GOOD;
        trim_fcs   = 1'b0;
        drop_frame = 1'b0;
        byte_next  = {bit_in, sh_q[7:1]};
        wr_data    = byte_next;
        if (bit_en) begin
            ones_d = bit_in ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
            if (!bit_in && ones_q == 3'd6) begin
                if (in_frame_q && nbytes_q != '0) begin
                    if (nbytes_q == NB_SAT && bitcnt_q == 3'd6) begin
                        ev_end     = 1'b1;
                        trim_fcs   = 1'b1;
                        end_result = (crc_q == CRC_RESIDUE) ? RES_GOOD : RES_CRC;
                    end else begin
                        drop_frame = 1'b1;
                    end
                end
                in_frame_d = 1'b1;
                bitcnt_d   = 3'd0;
                nbytes_d   = '0;
                crc_d      = CRC_PRESET;
            end else if (bit_in && ones_q == 3'd6) begin
                if (in_frame_q && nbytes_q != '0) begin
                    ev_end     = 1'b1;
                    end_result = RES_ABORT;
                end
                in_frame_d = 1'b0;
            end else if (ones_q < 3'd5 && in_frame_q) begin
                sh_d     = byte_next;
                bitcnt_d = bitcnt_q + 3'd1;
                if (bitcnt_q == 3'd7) begin
                    if (fifo_full) begin
                        ev_end     = 1'b1;
                        end_result = RES_OVERRUN;
                        in_frame_d = 1'b0;
                    end else begin
                        wr_en    = 1'b1;
                        crc_d    = crc_byte(crc_q, byte_next);
                        ev_start = (nbytes_q == '0);
                        if (nbytes_q != NB_SAT) nbytes_d = nbytes_q + NBW'(1);
                    end
                end
            end
        end
    end

    // State registers for the bit processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q     <= 3'd7;
            in_frame_q <= 1'b0;
            sh_q       <= '0;
            bitcnt_q   <= '0;
            nbytes_q   <= '0;
            crc_q      <= CRC_PRESET;
        end else begin
            ones_q     <= ones_d;
            in_frame_q <= in_frame_d;
            sh_q       <= sh_d;
            bitcnt_q   <= bitcnt_d;
            nbytes_q   <= nbytes_d;
            crc_q      <= crc_d;
        end
    end
endmodule

// File: rtl/hdlc_rx_fifo.sv
// Receive buffer with a commit pointer. Writes land beyond the commit
// point and become readable only on commit. A drop rewinds them, and a
// trimmed commit also removes the last two bytes (the check sequence).
// Assumes DEPTH is a power of two and that commit, drop and write never
// coincide.
module hdlc_rx_fifo #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic          trim,
    input  logic          drop,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic          full,
    output logic [PW-1:0] level,
    output logic [PW-1:0] avail
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_q, com_q, rd_q;
    logic          rd_fire;

    assign level    = wr_q - rd_q;
    assign avail    = com_q - rd_q;
    assign full     = (level == PW'(DEPTH));
    assign rd_valid = (avail != '0);
    assign rd_fire  = rd_en && rd_valid;
    assign rd_data  = mem[rd_q[AW-1:0]];

    // Byte storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_q[AW-1:0]] <= wr_data;
    end

    // Read, write and commit pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            com_q <= '0;
            rd_q  <= '0;
        end else begin
            if (rd_fire) rd_q <= rd_q + PW'(1);
            if (commit && trim) begin
                wr_q  <= wr_q - PW'(2);
                com_q <= wr_q - PW'(2);
            end else if (commit) begin
                com_q <= wr_q;
            end else if (drop) begin
                wr_q <= com_q;
            end else if (wr_en) begin
                wr_q <= wr_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_status_regs.sv
// Sticky status bits and the last packet result. A status read clears the
// bits. An event or a condition in the same cycle sets them again.
module hdlc_rx_status_regs
    import hdlc_rx_pkg::*;
#(
    parameter int LW   = 7,
    parameter int HALF = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_end,
    input  rx_result_e    end_result,
    input  logic [LW-1:0] level,
    input  logic          status_rd,
    output logic          st_start,
    output logic          st_end,
    output logic          st_half,
    output logic [1:0]    result
);
    logic over_half;
    assign over_half = (level > LW'(HALF));

    // Sticky set/clear and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_start <= 1'b0;
            st_end   <= 1'b0;
            st_half  <= 1'b0;
            result   <= 2'd0;
        end else begin
            st_start <= ev_start  | (st_start & ~status_rd);
            st_end   <= ev_end    | (st_end   & ~status_rd);
            st_half  <= over_half | (st_half  & ~status_rd);
            if (ev_end) result <= end_result;
        end
    end
endmodule

// File: rtl/hdlc_rx_status.sv
// Top level of the HDLC receive controller. It connects the bit processor,
// the commit-pointer buffer and the status registers.
// Assumes one line bit per enabled cycle and single-cycle host pulses.
module hdlc_rx_status
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int MIN_BYTES = 4,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rx_bit,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    input  logic       status_rd,
    output logic       stat_start,
    output logic       stat_end,
    output logic       stat_half,
    output logic [1:0] end_code
);
    logic          wr_en, ev_start, ev_end, trim_fcs, drop_frame, fifo_full;
    logic [7:0]    wr_data;
    rx_result_e    end_result;
    logic [LW-1:0] fifo_level, fifo_avail;

    hdlc_rx_bitproc #(.MIN_BYTES(MIN_BYTES)) u_bitproc (
        .clk(clk), .rst_n(rst_n), .bit_en(rx_en), .bit_in(rx_bit),
        .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data),
        .ev_start(ev_start), .ev_end(ev_end), .end_result(end_result),
        .trim_fcs(trim_fcs), .drop_frame(drop_frame)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .commit(ev_end), .trim(trim_fcs), .drop(drop_frame), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .full(fifo_full),
        .level(fifo_level), .avail(fifo_avail)
    );

    hdlc_rx_status_regs #(.LW(LW), .HALF(DEPTH / 2)) u_status (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_end(ev_end),
        .end_result(end_result), .level(fifo_level), .status_rd(status_rd),
        .st_start(stat_start), .st_end(stat_end), .st_half(stat_half),
        .result(end_code)
    );
endmodule

// File: rtl/hdlc_rx_status_chk.sv
// Property checker for the HDLC receive controller, attached by bind.
module hdlc_rx_status_chk #(
    parameter int DEPTH = 64,
    parameter int LW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] level,
    input logic [LW-1:0] avail,
    input logic          ev_end,
    input logic [1:0]    end_result,
    input logic [1:0]    end_code,
    input logic          stat_half
);
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    assert_readable_within_R12: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= level);

    assert_overrun_only_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_end && end_result == 2'd2) |-> level == LW'(DEPTH));

    assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_end |=> $stable(end_code));

    assert_half_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (level > LW'(DEPTH / 2)) |=> stat_half);
endmodule

bind hdlc_rx_status hdlc_rx_status_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .level(fifo_level), .avail(fifo_avail),
    .ev_end(ev_end), .end_result(end_result), .end_code(end_code),
    .stat_half(stat_half)
);

// File: tb/hdlc_rx_status_bench.sv
`timescale 1ns/1ps
module hdlc_rx_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, rx_bit = 1'b0, rd_en = 1'b0, status_rd = 1'b0;
    logic [7:0] rd_data;
    logic rd_valid, stat_start, stat_end, stat_half;
    logic [1:0] end_code;
    int tests = 0, fails = 0, ones_run = 0;
    bit done = 1'b0;
    logic [7:0] pkt [0:127];

    always #4 clk = ~clk;

    hdlc_rx_status u_hdlc_rx_status (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .status_rd(status_rd),
        .stat_start(stat_start), .stat_end(stat_end), .stat_half(stat_half),
        .end_code(end_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b; rx_en = 1'b1;
        @(negedge clk); rx_en = 1'b0; rx_bit = ~b;
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        ones_run = 0;
    endtask

    task automatic send_flag();
        send_raw(8'h7E);
    endtask

    task automatic send_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) begin
                ones_run++;
                if (ones_run == 5) begin send_bit(1'b0); ones_run = 0; end
            end else ones_run = 0;
        end
    endtask

    task automatic send_body(input int n);
        for (int i = 0; i < n; i++) send_stuffed(pkt[i]);
    endtask

    function automatic logic [7:0] data_of(input int len, input int i);
        if (i == 0 && (len % 2) == 1) return 8'hFF;
        if (i == 1) return 8'h7E;
        return 8'((len * 29 + i * 47 + 31) % 256);
    endfunction

    // Fill pkt with len payload bytes and a valid check sequence.
    task automatic build(input int len);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            pkt[i] = data_of(len, i);
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ pkt[i][k]) c = (c >> 1) ^ 16'h8408;
                else                  c = c >> 1;
            end
        end
        c = ~c;
        pkt[len]     = c[7:0];
        pkt[len + 1] = c[15:8];
    endtask

    task automatic read_status();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic drain(input string req, input int from, input int n);
        for (int i = from; i < from + n; i++) begin
            chk(req, int'(rd_valid), 1);
            chk(req, int'(rd_data), int'(pkt[i]));
            @(negedge clk); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 start", int'(stat_start), 0);
        chk("R11 end", int'(stat_end), 0);
        chk("R11 half", int'(stat_half), 0);
        chk("R11 code", int'(end_code), 0);
        chk("R11 valid", int'(rd_valid), 0);
        // R12: read while empty has no effect
        @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R12 empty read", int'(rd_valid), 0);

        // R13: idle ones and repeated flags raise nothing
        send_raw(8'hFF); send_flag(); send_flag(); send_raw(8'hFF); send_raw(8'hFF);
        chk("R13 idle start", int'(stat_start), 0);
        chk("R13 idle end", int'(stat_end), 0);

        // R1 R2 R6 R10 R13: sweep of good frames sharing flags
        send_flag();
        for (int len = 2; len <= 12; len++) begin
            build(len);
            send_body(len + 2);
            if (len == 5) chk("R12 not visible before close", int'(rd_valid), 0);
            send_flag();
            chk("R1 start", int'(stat_start), 1);
            chk("R2 end", int'(stat_end), 1);
            chk("R2 code", int'(end_code), 0);
            send_flag();
            chk("R10 sticky", int'(stat_end), 1);
            read_status();
            chk("R10 cleared end", int'(stat_end), 0);
            chk("R10 cleared start", int'(stat_start), 0);
            drain("R2 payload", 0, len);
            chk("R2 no fcs", int'(rd_valid), 0);
        end

        // R7: frames of 1..3 bytes are dropped
        for (int n = 1; n <= 3; n++) begin
            build(1);
            send_flag(); send_body(n); send_flag();
            chk("R7 no end", int'(stat_end), 0);
            chk("R7 no data", int'(rd_valid), 0);
            read_status();
        end

        // R8: closing flag off a byte boundary
        build(4);
        send_flag(); send_body(6);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        send_flag();
        chk("R8 no end", int'(stat_end), 0);
        chk("R8 no data", int'(rd_valid), 0);
        read_status();
        build(3);
        send_flag(); send_body(5); send_flag();
        chk("R8 next code", int'(end_code), 0);
        read_status();
        drain("R8 next frame", 0, 3);
        chk("R8 next empty", int'(rd_valid), 0);

        // R3: corrupted check sequence
        build(5);
        pkt[5] = pkt[5] ^ 8'h01;
        send_flag(); send_body(7); send_flag();
        chk("R3 end", int'(stat_end), 1);
        chk("R3 code", int'(end_code), 1);
        read_status();
        drain("R3 payload", 0, 5);
        chk("R3 trimmed", int'(rd_valid), 0);

        // R5: abort after three bytes
        build(3);
        send_flag(); send_body(3); send_raw(8'hFF);
        chk("R5 end", int'(stat_end), 1);
        chk("R5 code", int'(end_code), 3);
        read_status();
        drain("R5 kept", 0, 3);
        chk("R5 empty", int'(rd_valid), 0);

        // R9: half-full boundary at 33 versus 32 bytes
        build(40);
        send_flag(); send_body(42); send_flag();
        chk("R9 code", int'(end_code), 0);
        chk("R9 half set", int'(stat_half), 1);
        drain("R9 data", 0, 7);
        read_status();
        chk("R9 half at 33", int'(stat_half), 1);
        drain("R9 data", 7, 1);
        read_status();
        chk("R9 half at 32", int'(stat_half), 0);
        drain("R9 data", 8, 32);
        chk("R9 empty", int'(rd_valid), 0);
        read_status();

        // R4: overrun with 70 payload bytes and no host reads
        build(70);
        send_flag(); send_body(72); send_flag();
        chk("R4 end", int'(stat_end), 1);
        chk("R4 code", int'(end_code), 2);
        read_status();
        drain("R4 kept", 0, 64);
        chk("R4 rest discarded", int'(rd_valid), 0);
        read_status();
        build(2);
        send_flag(); send_body(4); send_flag();
        chk("R4 recovery code", int'(end_code), 0);
        drain("R4 recovery", 0, 2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule